// File: doc/BRIEF.md
# RTC Once-per-Second Update Sequencer

This block drives the once-per-second time update of a real-time clock whose time base is a 32.768 kHz enable (`tick`) sampled in the system clock domain. A down-counting prescaler stands in for the divider chain and sets the start of every update. A small state machine raises an update-in-progress flag a fixed number of ticks ahead of each update and keeps it high through the update window. While the window runs, the seconds, minutes, hours and alarm registers are locked. When the window ends, the time advances by one second. The new time is then compared with the three alarm registers, and any alarm field whose two top bits are both set matches every value.

Software reaches the block through a flat register port. Addresses 0x0 to 0x5 hold seconds, seconds-alarm, minutes, minutes-alarm, hours and hours-alarm. Address 0xA is control A: bit 7 is the read-only update flag, bits 6:4 are the divider code and bits 3:0 are a stored rate field. Address 0xB is control B, and bit 7 is the update-inhibit bit. Address 0xC holds the flags, with the alarm flag in bit 5, which a read clears. Address 0xD always reads 0x80. Unused addresses read 0.

The state machine has six states. HOLD: the divider is held in reset and the prescaler is preloaded to half a second. STOP: the prescaler is frozen. INHIBIT: the prescaler runs but no update happens. COUNT: normal counting. LEAD: the update flag is high and the update has not started. UPDATE: the update window, with the registers locked.

The state machine checks its inputs in a fixed priority order:
- A divider code of 11x forces HOLD.
- Otherwise the inhibit bit forces INHIBIT.
- Otherwise any divider code other than 010 forces STOP.
- Otherwise the normal path applies: HOLD, STOP and INHIBIT return to COUNT; COUNT goes to LEAD when the prescaler reaches the lead distance; COUNT or LEAD goes to UPDATE when the prescaler wraps; UPDATE goes back to COUNT when its tick count runs out, and that step commits the new time.

Top module: `rtc_update_seq`

## Requirements
- R1: After reset, control A reads 0x60 (divider code 110, update flag 0), the time registers read 0, the flags register reads 0 and `alarm_flag` is 0.
- R2: Divider code 010 runs the prescaler. Codes 110 and 111 hold it in reset, and every other code freezes it. In both the held and the frozen case no update occurs and control A bit 7 stays 0.
- R3: After the divider code changes from 11x to 010, control A bit 7 rises LEAD_TICKS fewer than HALF ticks later (HALF = TICKS_PER_SEC/2), with one tick of slack for the release edge. The update therefore starts half a second after release.
- R4: Control A bit 7 stays high for exactly LEAD_TICKS+UPDATE_TICKS ticks, and it rises once every TICKS_PER_SEC ticks.
- R5: At the end of each update, seconds count up by one. A seconds value of 59 or more wraps to 0 and carries into minutes. A minutes value of 59 or more wraps and carries into hours, and an hours value of 23 or more wraps to 0.
- R6: While an update runs, reads of addresses 0x0–0x5 return 0xEE and writes to them are dropped. Control A and control B stay readable and writable.
- R7: When control B bit 7 is written to 1, control A bit 7 reads 0 within two clock cycles, and no update happens while the bit stays set.
- R8: At each update commit the new time is compared with the alarms. A field matches when it is equal or when its bits 7:6 are 11. If all three fields match, flags bit 5 and `alarm_flag` are set. If any field differs, neither is set.
- R9: The alarm flag is sticky until the flags register (0xC) is read with `re` high. If a commit that sets the flag falls in the same cycle as such a read, the flag stays set.
- R10: Control A bit 7 ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse at the 32.768 kHz rate |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe; clears the alarm flag when addressing 0xC |
| rdata | output | 8 | Read data for `addr` (combinational) |
| alarm_flag | output | 1 | Sticky alarm flag |

## Verification
The alarm-set path and the clear-on-read path can both act on the flag in the same clock edge. The bench provokes this by setting a seconds alarm that the next update will match. It then holds a read of the flags register with `re` high through every cycle of the update window, including the commit tick, and drops it right after. The result is judged correct only if `alarm_flag` is still high and the seconds register has advanced, which shows the update really committed during the read.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        ST_HOLD, ST_STOP, ST_INHIBIT, ST_COUNT, ST_LEAD, ST_UPDATE
    } rtc_state_t;

    localparam logic [ADDR_W-1:0] A_SEC    = 4'h0;
    localparam logic [ADDR_W-1:0] A_SEC_AL = 4'h1;
    localparam logic [ADDR_W-1:0] A_MIN    = 4'h2;
    localparam logic [ADDR_W-1:0] A_MIN_AL = 4'h3;
    localparam logic [ADDR_W-1:0] A_HR     = 4'h4;
    localparam logic [ADDR_W-1:0] A_HR_AL  = 4'h5;
    localparam logic [ADDR_W-1:0] A_CTLA   = 4'hA;
    localparam logic [ADDR_W-1:0] A_CTLB   = 4'hB;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'hC;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'hD;

    localparam logic [2:0] DV_RUN = 3'b010;
endpackage

// File: rtl/rtc_tick_chain.sv
module rtc_tick_chain #(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned HALF          = TICKS_PER_SEC / 2,
    localparam int unsigned W            = $clog2(TICKS_PER_SEC + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         load_half,
    output logic [W-1:0] till,
    output logic         wrap
);
    // wrap marks the tick on which an update starts
    assign wrap = run && tick && (till <= W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            till <= W'(HALF);
        else if (load_half)
            till <= W'(HALF);
        else if (run && tick)
            till <= (till <= W'(1)) ? W'(TICKS_PER_SEC) : till - W'(1);
    end

    // R3: leaving the held state starts exactly half a second from the update
    a_r3_release_half: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_half && $past(load_half)) |-> (till == W'(HALF)));
endmodule

// File: rtl/rtc_clock_regs.sv
module rtc_clock_regs
    import rtc_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              commit,
    output logic [DATA_W-1:0] rd_val,
    output logic              alarm_hit
);
    logic [DATA_W-1:0] sec_q, min_q, hr_q, asec_q, amin_q, ahr_q;
    logic [DATA_W-1:0] sec_n, min_n, hr_n;
    logic              c_sec, c_min;

    function automatic logic field_ok(input logic [DATA_W-1:0] al, input logic [DATA_W-1:0] v);
        return (al[DATA_W-1:DATA_W-2] == 2'b11) || (al == v);
    endfunction

    always_comb begin
        c_sec = (sec_q >= DATA_W'(59));
        c_min = c_sec && (min_q >= DATA_W'(59));
        sec_n = c_sec ? '0 : sec_q + DATA_W'(1);
        min_n = c_sec ? ((min_q >= DATA_W'(59)) ? '0 : min_q + DATA_W'(1)) : min_q;
        hr_n  = c_min ? ((hr_q >= DATA_W'(23)) ? '0 : hr_q + DATA_W'(1)) : hr_q;
        alarm_hit = commit && field_ok(asec_q, sec_n) && field_ok(amin_q, min_n)
                    && field_ok(ahr_q, hr_n);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0; min_q <= '0; hr_q <= '0;
        end else if (commit) begin
            sec_q <= sec_n; min_q <= min_n; hr_q <= hr_n;
        end else if (wr_en) begin
            case (addr)
                A_SEC: sec_q <= wdata;
                A_MIN: min_q <= wdata;
                A_HR:  hr_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asec_q <= '0; amin_q <= '0; ahr_q <= '0;
        end else if (wr_en) begin
            case (addr)
                A_SEC_AL: asec_q <= wdata;
                A_MIN_AL: amin_q <= wdata;
                A_HR_AL:  ahr_q  <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            A_SEC:    rd_val = sec_q;
            A_SEC_AL: rd_val = asec_q;
            A_MIN:    rd_val = min_q;
            A_MIN_AL: rd_val = amin_q;
            A_HR:     rd_val = hr_q;
            A_HR_AL:  rd_val = ahr_q;
            default:  rd_val = '0;
        endcase
    end

    // R5/R6: time changes only through a commit or an allowed write
    a_r6_time_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !wr_en) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));
    // R5: seconds never leave the 0..59 range through a commit
    a_r5_commit_range: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (sec_q <= DATA_W'(59)));
endmodule

// File: rtl/rtc_update_seq.sv
module rtc_update_seq
    import rtc_upd_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768,
    parameter int unsigned LEAD_TICKS    = 8,
    parameter int unsigned UPDATE_TICKS  = 64,
    parameter logic [7:0]  POISON        = 8'hEE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              re,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm_flag
);
    localparam int unsigned HALF = TICKS_PER_SEC / 2;
    localparam int unsigned TW   = $clog2(TICKS_PER_SEC + 1);
    localparam int unsigned UW   = $clog2(UPDATE_TICKS + 1);

    rtc_state_t        st_q, st_d;
    logic [2:0]        dv_q;
    logic [3:0]        rs_q;
    logic [DATA_W-1:0] ctlb_q;
    logic              flag_q;
    logic [UW-1:0]     ucnt_q;
    logic [TW-1:0]     till;
    logic              wrap, run, load_half, uip, busy, commit, alarm_hit;
    logic              dv_hold, dv_run, set_bit, wr_time, flag_rd;
    logic [DATA_W-1:0] time_rd;

    assign dv_hold = (dv_q[2:1] == 2'b11);
    assign dv_run  = (dv_q == DV_RUN);
    assign set_bit = ctlb_q[DATA_W-1];
    assign flag_rd = re && (addr == A_FLAGS);

    rtc_tick_chain #(.TICKS_PER_SEC(TICKS_PER_SEC), .HALF(HALF)) u_chain (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .load_half(load_half), .till(till), .wrap(wrap)
    );

    rtc_clock_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_time), .addr(addr), .wdata(wdata),
        .commit(commit), .rd_val(time_rd), .alarm_hit(alarm_hit)
    );

    // next-state selection: hold > inhibit > stop > normal sequence
    always_comb begin
        st_d = st_q;
        if (dv_hold)      st_d = ST_HOLD;
        else if (set_bit) st_d = ST_INHIBIT;
        else if (!dv_run) st_d = ST_STOP;
        else begin
            unique case (st_q)
                ST_HOLD, ST_STOP, ST_INHIBIT: st_d = ST_COUNT;
                ST_COUNT:  if (wrap) st_d = ST_UPDATE;
                           else if (till <= TW'(LEAD_TICKS)) st_d = ST_LEAD;
                ST_LEAD:   if (wrap) st_d = ST_UPDATE;
                ST_UPDATE: if (tick && ucnt_q == UW'(1)) st_d = ST_COUNT;
                default:   st_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    // outputs decoded from the state
    always_comb begin
        uip       = (st_q == ST_LEAD) || (st_q == ST_UPDATE);
        busy      = (st_q == ST_UPDATE);
        load_half = (st_q == ST_HOLD);
        run       = (st_q == ST_COUNT) || (st_q == ST_LEAD) ||
                    (st_q == ST_UPDATE) || (st_q == ST_INHIBIT);
        commit    = (st_q == ST_UPDATE) && (st_d == ST_COUNT);
        wr_time   = we && !busy && (addr <= A_HR_AL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ucnt_q <= '0;
        else if (wrap)
            ucnt_q <= UW'(UPDATE_TICKS);
        else if (busy && tick && ucnt_q != '0)
            ucnt_q <= ucnt_q - UW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q   <= 3'b110;
            rs_q   <= '0;
            ctlb_q <= '0;
        end else if (we) begin
            if (addr == A_CTLA) begin
                dv_q <= wdata[6:4];
                rs_q <= wdata[3:0];
            end
            if (addr == A_CTLB) ctlb_q <= wdata;
        end
    end

    // set has priority over clear-on-read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (alarm_hit) flag_q <= 1'b1;
        else if (flag_rd)   flag_q <= 1'b0;
    end

    assign alarm_flag = flag_q;

    always_comb begin
        if (addr <= A_HR_AL)        rdata = busy ? POISON : time_rd;
        else if (addr == A_CTLA)    rdata = {uip, dv_q, rs_q};
        else if (addr == A_CTLB)    rdata = ctlb_q;
        else if (addr == A_FLAGS)   rdata = {2'b00, flag_q, 5'b0};
        else if (addr == A_STAT)    rdata = 8'h80;
        else                        rdata = '0;
    end

    // R7: a held inhibit bit keeps the update flag low
    a_r7_set_clears_uip: assert property (@(posedge clk) disable iff (!rst_n)
        (set_bit && $past(set_bit)) |-> !uip);
    // R2: a held divider never raises the update flag
    a_r2_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (dv_hold && $past(dv_hold)) |-> !uip);
    // R9: flag stays set unless a flags read clears it
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_rd) |=> flag_q);
    // R9: a matching commit always leaves the flag set, read or not
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> flag_q);
    // R4: update window counter stays within its bound while updating
    a_r4_update_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (ucnt_q != '0 && ucnt_q <= UW'(UPDATE_TICKS)));
endmodule

// File: tb/tb_rtc_update_seq.sv
`timescale 1ns/1ps
module tb_rtc_update_seq;
    localparam int TPS  = 64;
    localparam int LEAD = 8;
    localparam int UPD  = 16;
    localparam int HALF = TPS / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [7:0] rdata;
    logic       alarm_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int tick_count = 0;
    bit finished = 1'b0;

    rtc_update_seq #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD), .UPDATE_TICKS(UPD)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
        .we(we), .re(re), .rdata(rdata), .alarm_flag(alarm_flag)
    );

    always #2 clk = ~clk;

    initial begin
        int cyc = 0;
        forever begin
            @(negedge clk);
            cyc++;
            tick = (cyc % 4 == 0);
        end
    end

    always @(posedge clk) if (rst_n && tick) tick_count <= tick_count + 1;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; re = 1'b0; #1; v = rdata;
    endtask

    task automatic rd_clr(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; re = 1'b1; #1; v = rdata;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic wait_uip(input bit level, output int tc);
        forever begin
            @(negedge clk); addr = 4'hA; re = 1'b0; #1;
            if (rdata[7] == level) break;
        end
        tc = tick_count;
    endtask

    task automatic watch_ticks(input int n, output bit seen);
        int start = tick_count;
        seen = 1'b0;
        while (tick_count < start + n) begin
            @(negedge clk); addr = 4'hA; re = 1'b0; #1;
            if (rdata[7]) seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'hA, v);  chk("R1 ctlA", v, 8'h60);
        rd(4'h0, v);  chk("R1 sec", v, 0);
        rd(4'hC, v);  chk("R1 flags", v, 0);
        chk("R1 alarm_flag", alarm_flag, 0);
    endtask

    task automatic t_release_rollover();
        logic [7:0] v; bit seen; int t0, t1, t2, d;
        wr(4'h0, 8'd59); wr(4'h2, 8'd59); wr(4'h4, 8'd23);
        wr(4'h1, 8'd0);  wr(4'h3, 8'd0);  wr(4'h5, 8'd0);
        watch_ticks(2 * TPS, seen);
        chk("R2 held no uip", seen, 0);
        rd(4'h0, v); chk("R2 held sec", v, 59);
        wr(4'hA, 8'h20); t0 = tick_count;
        wait_uip(1'b1, t1);
        d = t1 - t0;
        chk("R3 half-second release", (d == HALF - LEAD || d == HALF - LEAD + 1), 1);
        wait_uip(1'b0, t2);
        chk("R4 uip width", t2 - t1, LEAD + UPD);
        rd(4'h0, v); chk("R5 sec wrap", v, 0);
        rd(4'h2, v); chk("R5 min wrap", v, 0);
        rd(4'h4, v); chk("R5 hour wrap", v, 0);
        chk("R8 exact alarm", alarm_flag, 1);
        rd_clr(4'hC, v); chk("R8 flags bit5", v, 8'h20);
        rd(4'hC, v); chk("R9 cleared by read", v, 0);
    endtask

    task automatic t_period();
        int a, b, x;
        wait_uip(1'b1, a); wait_uip(1'b0, x); wait_uip(1'b1, b);
        chk("R4 period", b - a, TPS);
        wait_uip(1'b0, x);
    endtask

    task automatic t_update_access();
        logic [7:0] s0, v; bit seen; int x;
        rd(4'h0, s0);
        wait_uip(1'b1, x);
        watch_ticks(LEAD + 2, seen);
        rd(4'h0, v); chk("R6 poison", v, 8'hEE);
        rd(4'hA, v); chk("R6 ctlA readable", v[7], 1);
        wr(4'h0, 8'h33);
        wr(4'hB, 8'h12);
        rd(4'hB, v); chk("R6 ctlB writable", v, 8'h12);
        wait_uip(1'b0, x);
        rd(4'h0, v); chk("R6 write dropped / R5 inc", v, s0 + 1);
        wr(4'hB, 8'h00);
    endtask

    task automatic t_stop();
        logic [7:0] s0, v; bit seen; int x;
        wr(4'hA, 8'h00);
        rd(4'h0, s0);
        watch_ticks(2 * TPS, seen);
        chk("R2 stop no uip", seen, 0);
        rd(4'h0, v); chk("R2 stop frozen", v, s0);
        wr(4'hA, 8'h20);
        wait_uip(1'b1, x); wait_uip(1'b0, x);
    endtask

    task automatic t_set();
        logic [7:0] s0, v; bit seen; int x;
        wait_uip(1'b1, x);
        wr(4'hB, 8'h80);
        rd(4'hA, v); chk("R7 uip cleared", v[7], 0);
        rd(4'h0, s0);
        watch_ticks(2 * TPS, seen);
        chk("R7 no uip while set", seen, 0);
        rd(4'h0, v); chk("R7 no update while set", v, s0);
        wr(4'hB, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] v; int x;
        wait_uip(1'b1, x); wait_uip(1'b0, x);
        wr(4'hA, 8'hA0);
        rd(4'hA, v); chk("R10 uip read-only", v, 8'h20);
    endtask

    task automatic t_dontcare();
        logic [7:0] s0, v; int x;
        rd(4'h0, s0);
        wr(4'h1, s0 + 1); wr(4'h3, 8'hFF); wr(4'h5, 8'hC5);
        rd_clr(4'hC, v);
        wait_uip(1'b1, x); wait_uip(1'b0, x);
        chk("R8 dont-care match", alarm_flag, 1);
        rd_clr(4'hC, v); chk("R8 dont-care flags", v, 8'h20);
    endtask

    task automatic t_mismatch();
        logic [7:0] s0, v; int x;
        rd(4'h0, s0);
        wr(4'h1, s0 + 5);
        wait_uip(1'b1, x); wait_uip(1'b0, x);
        rd(4'hC, v); chk("R8 mismatch flags", v, 0);
        chk("R8 mismatch output", alarm_flag, 0);
    endtask

    task automatic t_collision();
        logic [7:0] s0, v; int t1;
        rd(4'h0, s0);
        wr(4'h1, s0 + 1);
        rd_clr(4'hC, v);
        wait_uip(1'b1, t1);
        forever begin
            @(negedge clk);
            if (tick_count < t1 + LEAD + UPD) begin addr = 4'hC; re = 1'b1; end
            else begin re = 1'b0; break; end
        end
        #1;
        chk("R9 set wins over read", alarm_flag, 1);
        rd(4'h0, v); chk("R9 update committed", v, s0 + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_release_rollover();
        t_period();
        t_update_access();
        t_stop();
        t_set();
        t_readonly();
        t_dontcare();
        t_mismatch();
        t_collision();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule